// File: doc/BRIEF.md
# Byte Copy Engine with Completion Interrupt

This block moves a run of bytes from one 24-bit address to another, one byte per clock. Software loads a source address, a target address and a 16-bit byte count through a write-only register port, then sets a start bit. The engine issues each read address from a counter, and the memory returns the byte in the same cycle. The engine writes that byte to the matching target address. Bytes move in ascending address order.

The block reports busy while a copy runs or while an external cache-fill input is high. The cycle after the combined busy status drops, a sticky interrupt-pending bit is set. That bit drives the interrupt line unless interrupts are masked. A separate suspend command can freeze the engine for a set number of cycles, or indefinitely until it is released.

Top module: `byte_dma_engine`

## Requirements
- R1: After synchronous reset the source, target and count settings are zero, no copy runs, busy_o, irq_pending_o, irq_o and mem_wr_en are low, mem_rd_addr is zero and the engine is not suspended.
- R2: A start with count L>0 produces exactly L consecutive cycles with mem_wr_en high, starting in the cycle after the start write. In cycle n (n = 0 to L-1) mem_rd_addr = source+n, mem_wr_addr = target+n (modulo 2^24) and mem_wr_data = mem_rd_data. The copy ends at the last byte.
- R3: busy_o is the OR of the copy-active state and cache_loading_i. Copy-active is high for L cycles after a start, or for 1 cycle when L=0.
- R4: A start with count zero makes no memory write, holds copy-active for one cycle and then sets interrupt-pending.
- R5: When busy was high in the previous unfrozen cycle and is low now, irq_pending_o is high from the next cycle. It stays high until it is acknowledged.
- R6: irq_o is high exactly when irq_pending_o is high and the mask bit is 0.
- R7: A control write with bit 1 set clears interrupt-pending. When it falls in the same cycle as a set, the clear wins.
- R8: A suspend write with bit 16 set and count N>0 freezes the copy and the busy-edge detector for N cycles. With N=0 the freeze lasts until a suspend write with bit 16 clear. While frozen, no byte moves.
- R9: A start request while a copy is active is ignored.
- R10: Register addresses are: 0 source, 1 target, 2 count (bits 15:0), 3 control (bit 0 start, bit 1 acknowledge), 4 mask (bit 0), 5 suspend (bit 16 hold, bits 15:0 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| cache_loading_i | input | 1 | External cache-fill busy indication |
| mem_rd_addr | output | 24 | Source byte address |
| mem_rd_data | input | 8 | Byte read from mem_rd_addr, same cycle |
| mem_wr_en | output | 1 | Target write enable |
| mem_wr_addr | output | 24 | Target byte address |
| mem_wr_data | output | 8 | Byte to write |
| busy_o | output | 1 | Combined busy status |
| irq_pending_o | output | 1 | Sticky interrupt-pending bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The copy is exercised with several patterns:
- A multi-byte run whose source crosses a 16-bit carry, which separates ascending counting from wrap and stride errors.
- A single-byte run whose acknowledge lands on the set cycle, which separates the two priorities of clear versus set.
- A zero count, which separates an immediate finish from a wrap-around to 65536 bytes.
- A second start issued mid-copy, which shows whether the running counters get reloaded.

Counted and indefinite suspends given mid-copy and before a start, and a cache-fill pulse, show whether the freeze stops every byte and whether the interrupt follows the combined busy status rather than the copy alone.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam logic [2:0] RA_SRC    = 3'd0;
  localparam logic [2:0] RA_DST    = 3'd1;
  localparam logic [2:0] RA_LEN    = 3'd2;
  localparam logic [2:0] RA_CTRL   = 3'd3;
  localparam logic [2:0] RA_MASK   = 3'd4;
  localparam logic [2:0] RA_SUSP   = 3'd5;
  localparam int CTRL_START_BIT    = 0;
  localparam int CTRL_ACK_BIT      = 1;
  localparam int SUSP_HOLD_BIT     = 16;
endpackage

// File: rtl/bdma_cfg.sv
module bdma_cfg
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int SUSP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              mask_o,
  output logic              start_o,
  output logic              ack_o,
  output logic              susp_wr_o,
  output logic              susp_hold_o,
  output logic [SUSP_W-1:0] susp_cnt_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      mask_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        RA_SRC:  src_q  <= wdata_i;
        RA_DST:  dst_q  <= wdata_i;
        RA_LEN:  len_q  <= wdata_i[LEN_W-1:0];
        RA_MASK: mask_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign len_o       = len_q;
  assign mask_o      = mask_q;
  assign start_o     = we_i && (addr_i == RA_CTRL) && wdata_i[CTRL_START_BIT];
  assign ack_o       = we_i && (addr_i == RA_CTRL) && wdata_i[CTRL_ACK_BIT];
  assign susp_wr_o   = we_i && (addr_i == RA_SUSP);
  assign susp_hold_o = wdata_i[SUSP_HOLD_BIT];
  assign susp_cnt_o  = wdata_i[SUSP_W-1:0];

  // R10: a source write lands in the source setting
  a_r10_src_write: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == RA_SRC) |=> (src_q == $past(wdata_i)));
  // R10: a count write lands in the count setting
  a_r10_len_write: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == RA_LEN) |=> (len_q == $past(wdata_i[LEN_W-1:0])));
endmodule

// File: rtl/bdma_susp.sv
module bdma_susp #(
  parameter int SUSP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              hold_i,
  input  logic [SUSP_W-1:0] cnt_i,
  output logic              stall_o
);
  logic              hold_q;
  logic [SUSP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_i) begin
      hold_q <= hold_i;
      cnt_q  <= hold_i ? cnt_i : '0;
    end else if (hold_q && cnt_q != '0) begin
      cnt_q <= cnt_q - SUSP_W'(1);
      if (cnt_q == SUSP_W'(1)) hold_q <= 1'b0;
    end
  end

  assign stall_o = hold_q;

  // R8: a counted freeze ends when its count runs out
  a_r8_count_expires: assert property (@(posedge clk) disable iff (rst)
    (hold_q && cnt_q == SUSP_W'(1) && !wr_i) |=> !hold_q);
  // R8: a freeze with zero count persists until released
  a_r8_hold_persists: assert property (@(posedge clk) disable iff (rst)
    (hold_q && cnt_q == '0 && !wr_i) |=> hold_q);
endmodule

// File: rtl/bdma_xfer.sv
module bdma_xfer #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stall_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_en_o
);
  logic              active_q;
  logic [ADDR_W-1:0] rd_q, wr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              step;

  assign step = active_q && !stall_i && (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= '0;
      wr_q     <= '0;
      rem_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      rd_q     <= src_i;
      wr_q     <= dst_i;
      rem_q    <= len_i;
    end else if (active_q && !stall_i) begin
      if (rem_q == '0) begin
        active_q <= 1'b0;
      end else begin
        rd_q  <= rd_q + ADDR_W'(1);
        wr_q  <= wr_q + ADDR_W'(1);
        rem_q <= rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) active_q <= 1'b0;
      end
    end
  end

  assign active_o  = active_q;
  assign rd_addr_o = rd_q;
  assign wr_addr_o = wr_q;
  assign wr_en_o   = step;

  // R2: the last byte ends the copy
  a_r2_last_byte_ends: assert property (@(posedge clk) disable iff (rst)
    (active_q && !stall_i && rem_q == LEN_W'(1)) |=> !active_q);
  // R2: consecutive bytes use ascending addresses
  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (step && !start_i) |=> (rd_q == $past(rd_q) + ADDR_W'(1)) && (wr_q == $past(wr_q) + ADDR_W'(1)));
  // R8 / R9: frozen or re-started copy keeps its counters
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (active_q && stall_i) |=> active_q && $stable(rd_q) && $stable(rem_q));
endmodule

// File: rtl/bdma_irq.sv
module bdma_irq (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic stall_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic pending_o,
  output logic irq_o
);
  logic busy_prev_q, pend_q, set_evt;

  assign set_evt = !stall_i && busy_prev_q && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_prev_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (!stall_i) busy_prev_q <= busy_i;
      if (ack_i)        pend_q <= 1'b0;
      else if (set_evt) pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = pend_q && !mask_i;

  // R5: pending is sticky until acknowledged
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> pend_q);
  // R5: a busy falling edge sets pending
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (set_evt && !ack_i) |=> pend_q);
  // R7: acknowledge clears, even against a set
  a_r7_ack_wins: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !pend_q);
endmodule

// File: rtl/byte_dma_engine.sv
module byte_dma_engine #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              cache_loading_i,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              busy_o,
  output logic              irq_pending_o,
  output logic              irq_o
);
  localparam int SUSP_W = 16;

  logic [ADDR_W-1:0] src_cfg, dst_cfg;
  logic [LEN_W-1:0]  len_cfg;
  logic              mask_cfg, start_req, ack_req;
  logic              susp_wr, susp_hold, stall, active;
  logic [SUSP_W-1:0] susp_cnt;

  bdma_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SUSP_W(SUSP_W)) cfg_i (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .src_o(src_cfg), .dst_o(dst_cfg), .len_o(len_cfg), .mask_o(mask_cfg),
    .start_o(start_req), .ack_o(ack_req), .susp_wr_o(susp_wr),
    .susp_hold_o(susp_hold), .susp_cnt_o(susp_cnt)
  );

  bdma_susp #(.SUSP_W(SUSP_W)) susp_i (
    .clk(clk), .rst(rst), .wr_i(susp_wr), .hold_i(susp_hold), .cnt_i(susp_cnt),
    .stall_o(stall)
  );

  bdma_xfer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) xfer_i (
    .clk(clk), .rst(rst), .start_i(start_req), .stall_i(stall),
    .src_i(src_cfg), .dst_i(dst_cfg), .len_i(len_cfg),
    .active_o(active), .rd_addr_o(mem_rd_addr), .wr_addr_o(mem_wr_addr),
    .wr_en_o(mem_wr_en)
  );

  assign busy_o      = active || cache_loading_i;
  assign mem_wr_data = mem_rd_data;

  bdma_irq irq_i (
    .clk(clk), .rst(rst), .busy_i(busy_o), .stall_i(stall), .ack_i(ack_req),
    .mask_i(mask_cfg), .pending_o(irq_pending_o), .irq_o(irq_o)
  );

  // R6: the interrupt line never rises without pending
  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_pending_o);
  // R2: a write only happens while busy
  a_r2_write_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy_o);
endmodule

// File: tb/byte_dma_engine_tb.sv
module byte_dma_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        cache_loading_i = 1'b0;
  logic [23:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data, mem_wr_data;
  logic        mem_wr_en, busy_o, irq_pending_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int n_writes = 0;
  int n_busy = 0;
  bit done = 0;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign mem_rd_data = pat(mem_rd_addr);

  byte_dma_engine dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cache_loading_i(cache_loading_i), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy_o(busy_o), .irq_pending_o(irq_pending_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [23:0] m_src, m_dst, m_rd, m_wr;
  int          m_len, m_rem, m_scnt;
  bit          m_active, m_susp, m_bprev, m_pend, m_mask;

  always @(posedge clk) begin
    bit busy_now, stall, ack, start, setp;
    if (rst) begin
      m_src = 0; m_dst = 0; m_rd = 0; m_wr = 0; m_len = 0; m_rem = 0; m_scnt = 0;
      m_active = 0; m_susp = 0; m_bprev = 0; m_pend = 0; m_mask = 0;
    end else begin
      busy_now = m_active || cache_loading_i;
      stall = m_susp;
      ack   = reg_we && reg_addr == 3 && reg_wdata[1];
      start = reg_we && reg_addr == 3 && reg_wdata[0];
      setp  = !stall && m_bprev && !busy_now;
      if (ack) m_pend = 0; else if (setp) m_pend = 1;
      if (!stall) m_bprev = busy_now;
      if (start && !m_active) begin
        m_active = 1; m_rd = m_src; m_wr = m_dst; m_rem = m_len;
      end else if (m_active && !stall) begin
        if (m_rem == 0) m_active = 0;
        else begin
          m_rd = m_rd + 24'd1; m_wr = m_wr + 24'd1; m_rem = m_rem - 1;
          if (m_rem == 0) m_active = 0;
        end
      end
      if (reg_we && reg_addr == 5) begin
        m_susp = reg_wdata[16];
        m_scnt = reg_wdata[16] ? int'(reg_wdata[15:0]) : 0;
      end else if (m_susp && m_scnt != 0) begin
        m_scnt = m_scnt - 1;
        if (m_scnt == 0) m_susp = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_src = reg_wdata;
          3'd1: m_dst = reg_wdata;
          3'd2: m_len = int'(reg_wdata[15:0]);
          3'd4: m_mask = reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the edge
  always @(posedge clk) begin
    bit e_wen;
    #3;
    if (!rst) begin
      e_wen = m_active && !m_susp && m_rem != 0;
      chk("R3 busy_o", 32'(busy_o), 32'(m_active || cache_loading_i));
      chk("R2 R8 mem_wr_en", 32'(mem_wr_en), 32'(e_wen));
      if (e_wen) begin
        chk("R2 R10 mem_rd_addr", 32'(mem_rd_addr), 32'(m_rd));
        chk("R2 mem_wr_addr", 32'(mem_wr_addr), 32'(m_wr));
        chk("R2 mem_wr_data", 32'(mem_wr_data), 32'(pat(m_rd)));
      end
      chk("R5 irq_pending_o", 32'(irq_pending_o), 32'(m_pend));
      chk("R6 irq_o", 32'(irq_o), 32'(m_pend && !m_mask));
      if (mem_wr_en) n_writes++;
      if (busy_o) n_busy++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w0, b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 pending", 32'(irq_pending_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 wr_en", 32'(mem_wr_en), 0);
    chk("R1 rd_addr", 32'(mem_rd_addr), 0);

    // R2 R5 R6: five bytes across a carry
    wr(3'd0, 24'h10FFFE); wr(3'd1, 24'h2000F0); wr(3'd2, 24'd5);
    w0 = n_writes;
    wr(3'd3, 24'h1);
    idle(8);
    chk("R2 byte count", 32'(n_writes - w0), 5);
    chk("R5 pending after copy", 32'(irq_pending_o), 1);
    chk("R6 irq raised", 32'(irq_o), 1);
    wr(3'd3, 24'h2);
    chk("R7 ack clears", 32'(irq_pending_o), 0);

    // R7 acknowledge on the set cycle
    wr(3'd2, 24'd1);
    wr(3'd3, 24'h1);
    idle(1);
    wr(3'd3, 24'h2);
    idle(2);
    chk("R7 ack wins over set", 32'(irq_pending_o), 0);

    // R6 masked interrupt
    wr(3'd4, 24'h1); wr(3'd2, 24'd3); wr(3'd3, 24'h1);
    idle(6);
    chk("R6 masked irq", 32'(irq_o), 0);
    chk("R5 pending while masked", 32'(irq_pending_o), 1);
    wr(3'd4, 24'h0);
    chk("R6 unmasked irq", 32'(irq_o), 1);
    wr(3'd3, 24'h2);

    // R4 zero count
    wr(3'd2, 24'd0);
    w0 = n_writes; b0 = n_busy;
    wr(3'd3, 24'h1);
    idle(3);
    chk("R4 no writes", 32'(n_writes - w0), 0);
    chk("R4 one busy cycle", 32'(n_busy - b0), 1);
    chk("R4 pending", 32'(irq_pending_o), 1);
    wr(3'd3, 24'h2);

    // R8 counted suspend mid-copy
    wr(3'd0, 24'h000100); wr(3'd2, 24'd6);
    w0 = n_writes; b0 = n_busy;
    wr(3'd3, 24'h1);
    idle(1);
    wr(3'd5, 24'h010003);
    idle(12);
    chk("R8 counted suspend busy cycles", 32'(n_busy - b0), 9);
    chk("R8 all bytes after suspend", 32'(n_writes - w0), 6);
    wr(3'd3, 24'h2);

    // R8 indefinite suspend
    wr(3'd2, 24'd2);
    w0 = n_writes;
    wr(3'd5, 24'h010000);
    wr(3'd3, 24'h1);
    idle(10);
    chk("R8 frozen no writes", 32'(n_writes - w0), 0);
    chk("R8 frozen still busy", 32'(busy_o), 1);
    wr(3'd5, 24'h000000);
    idle(4);
    chk("R8 resumed writes", 32'(n_writes - w0), 2);
    wr(3'd3, 24'h2);

    // R9 start while active
    wr(3'd2, 24'd4); wr(3'd1, 24'h300000);
    w0 = n_writes;
    wr(3'd3, 24'h1);
    wr(3'd2, 24'd9);
    wr(3'd3, 24'h1);
    idle(8);
    chk("R9 second start ignored", 32'(n_writes - w0), 4);
    wr(3'd3, 24'h2);

    // R3 cache fill produces completion
    cache_loading_i = 1'b1;
    idle(3);
    cache_loading_i = 1'b0;
    idle(3);
    chk("R3 cache fill sets pending", 32'(irq_pending_o), 1);
    wr(3'd3, 24'h2);
    idle(2);
    finish_run();
  end
endmodule